// File: doc/BRIEF.md
# Cascaded Interrupt Collector

This block gathers sixteen level-type interrupt sources into a single active-high request line that feeds an upstream interrupt controller. Each source is first brought into the local clock domain by a flop chain. A pending bit is then latched while the source is active and its enable bit is set. The request line is raised when at least one pending bit is both enabled and unmasked.

Software reaches the block through a simple word-addressed register port. Registers are 16 bits wide and sit at 4-byte spacing. The enable vector and the mask vector each have their own set address and clear address, so no read-modify-write is ever needed to change a single source. Pending sources are acknowledged by writing ones to the status address. A typical start-up writes all ones to the enable-clear, mask-clear and status addresses, then turns on individual sources as their handlers are installed.

Top module: `irq_cascade_hub`

## Requirements
- R1: After synchronous active-high reset, the enable vector, the mask vector and the status vector are all zero, and `irq_out` is low.
- R2: The register index is `bus_addr[4:2]`, and the two low address bits are ignored. Index 0 (0x00) is status, 1 (0x04) sets enable bits, 2 (0x08) clears enable bits, 3 (0x0C) sets mask bits and 4 (0x10) clears mask bits. `bus_rdata` is combinational on `bus_addr`. Addresses 0x04 and 0x08 both read the enable vector, 0x0C and 0x10 both read the mask vector, 0x00 reads status, and every other address reads zero. A write to an unused address changes nothing.
- R3: A write to 0x04 sets the enable bits written as 1, and a write to 0x08 clears them. Bits written as 0 keep their value. The new value is visible from the clock edge that takes the write.
- R4: A write to 0x0C sets the mask bits written as 1, and a write to 0x10 clears them. Bits written as 0 keep their value.
- R5: Status bit i becomes 1 on the third rising edge after `src_irq[i]` rises, because of two synchroniser stages and the latch, provided enable bit i is 1. A source whose enable bit is 0 never sets its status bit.
- R6: Writing 1 to a status bit acknowledges it, and bits written as 0 are left unchanged. If the synchronised source is still active with enable set, the set wins and the bit stays 1.
- R7: `irq_out` is registered. It equals the OR over i of (status[i] AND mask[i] AND enable[i]) as it stood one clock earlier.
- R8: A pending source with either its enable bit or its mask bit at 0 does not raise `irq_out`. A status bit that is already pending stays latched while it is gated off.
- R9: After 0xFFFF is written to 0x08, 0x10 and 0x00 in turn, all three vectors read zero and `irq_out` is low, even while sources stay active.
- R10: Several status bits can be pending at once, and a single read at 0x00 returns all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 16 | Asynchronous level interrupt sources, bit i is source i |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| irq_out | output | 1 | Registered cascaded interrupt request, active high |

## Verification
A write to an enable or mask address is visible at `bus_rdata` right after the edge that takes it, and `irq_out` follows one edge later. A source edge reaches the status read on the third edge and the request line on the fourth. The bench drives inputs on the falling edge. Each expected item is pushed into a queue timed to one particular rising edge, and the monitor compares it 1 ns after that edge. This timing lets the status read check the exact R5 latency cycle by cycle, and makes each gating change show up at `irq_out` on the edge it is due.

// File: rtl/icq_pkg.sv
package icq_pkg;

   // register indices (byte address = index * 4)
   localparam int unsigned IDX_STATUS  = 0;
   localparam int unsigned IDX_EN_SET  = 1;
   localparam int unsigned IDX_EN_CLR  = 2;
   localparam int unsigned IDX_MSK_SET = 3;
   localparam int unsigned IDX_MSK_CLR = 4;
   localparam int unsigned IDX_COUNT   = 5;

   typedef struct packed {
      logic st_ack;
      logic en_set;
      logic en_clr;
      logic mk_set;
      logic mk_clr;
   } icq_strobe_t;

   typedef enum logic [1:0] {
      RD_ZERO   = 2'd0,
      RD_STATUS = 2'd1,
      RD_ENABLE = 2'd2,
      RD_MASK   = 2'd3
   } icq_rdsel_e;

endpackage

// File: rtl/icq_sync.sv
module icq_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   initial begin : p_chk
      assert (STAGES >= 1) else $fatal(1, "icq_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= '0;
               else     chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[s] <= '0;
               else     chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/icq_decode.sv
module icq_decode
   import icq_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NSRC   = 16
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [NSRC-1:0]   en_vec,
   input  logic [NSRC-1:0]   mask_vec,
   input  logic [NSRC-1:0]   stat_vec,
   output icq_strobe_t       strobe,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   initial begin : p_chk
      assert (ADDR_W >= 2 && (1 << IDX_W) >= IDX_COUNT)
         else $fatal(1, "icq_decode: ADDR_W too small for register map");
      assert (NSRC <= DATA_W)
         else $fatal(1, "icq_decode: NSRC exceeds DATA_W");
   end

   logic [IDX_W-1:0] idx;
   logic [1:0]       unused_lo;
   icq_rdsel_e       rsel;
   logic [NSRC-1:0]  rvec;

   assign idx       = bus_addr[ADDR_W-1:2];
   assign unused_lo = bus_addr[1:0];

   always_comb begin
      strobe        = '0;
      strobe.st_ack = bus_wr && (idx == IDX_W'(IDX_STATUS));
      strobe.en_set = bus_wr && (idx == IDX_W'(IDX_EN_SET));
      strobe.en_clr = bus_wr && (idx == IDX_W'(IDX_EN_CLR));
      strobe.mk_set = bus_wr && (idx == IDX_W'(IDX_MSK_SET));
      strobe.mk_clr = bus_wr && (idx == IDX_W'(IDX_MSK_CLR));
   end

   always_comb begin
      if (idx == IDX_W'(IDX_STATUS))
         rsel = RD_STATUS;
      else if (idx == IDX_W'(IDX_EN_SET) || idx == IDX_W'(IDX_EN_CLR))
         rsel = RD_ENABLE;
      else if (idx == IDX_W'(IDX_MSK_SET) || idx == IDX_W'(IDX_MSK_CLR))
         rsel = RD_MASK;
      else
         rsel = RD_ZERO;
   end

   always_comb begin
      unique case (rsel)
         RD_STATUS: rvec = stat_vec;
         RD_ENABLE: rvec = en_vec;
         RD_MASK:   rvec = mask_vec;
         default:   rvec = '0;
      endcase
   end

   generate
      if (NSRC == DATA_W) begin : g_full
         assign rdata = rvec;
      end else begin : g_pad
         assign rdata = {{(DATA_W-NSRC){1'b0}}, rvec};
      end
   endgenerate

endmodule

// File: rtl/icq_setclr_reg.sv
module icq_setclr_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] bits,
   output logic [W-1:0] vec_q
);

   logic [W-1:0] set_m, clr_m;

   assign set_m = set_stb ? bits : '0;
   assign clr_m = clr_stb ? bits : '0;

   always_ff @(posedge clk) begin
      if (rst) vec_q <= '0;
      else     vec_q <= (vec_q & ~clr_m) | set_m;
   end

endmodule

// File: rtl/icq_pending.sv
module icq_pending #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] src_sync,
   input  logic [W-1:0] en_vec,
   input  logic         ack_stb,
   input  logic [W-1:0] ack_bits,
   output logic [W-1:0] stat_q
);

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         logic set_ev, clr_ev;
         assign set_ev = src_sync[i] & en_vec[i];
         assign clr_ev = ack_stb & ack_bits[i];
         always_ff @(posedge clk) begin
            if (rst)         stat_q[i] <= 1'b0;
            else if (set_ev) stat_q[i] <= 1'b1;   // set beats acknowledge
            else if (clr_ev) stat_q[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/irq_cascade_hub.sv
module irq_cascade_hub
   import icq_pkg::*;
#(
   parameter int unsigned NSRC        = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NSRC-1:0]   src_irq,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   initial begin : p_chk
      assert (NSRC >= 1 && NSRC <= DATA_W)
         else $fatal(1, "irq_cascade_hub: NSRC must be 1..DATA_W");
   end

   icq_strobe_t     strobe;
   logic [NSRC-1:0] wbits;
   logic [NSRC-1:0] src_s;
   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] live;

   generate
      if (NSRC == DATA_W) begin : g_wfull
         assign wbits = bus_wdata;
      end else begin : g_wpart
         logic [DATA_W-NSRC-1:0] unused_hi;
         assign unused_hi = bus_wdata[DATA_W-1:NSRC];
         assign wbits     = bus_wdata[NSRC-1:0];
      end
   endgenerate

   icq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (src_irq),
      .sync_out (src_s)
   );

   icq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_dec (
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .en_vec   (en_q),
      .mask_vec (mask_q),
      .stat_vec (stat_q),
      .strobe   (strobe),
      .rdata    (bus_rdata)
   );

   icq_setclr_reg #(.W(NSRC)) u_en (
      .clk     (clk),
      .rst     (rst),
      .set_stb (strobe.en_set),
      .clr_stb (strobe.en_clr),
      .bits    (wbits),
      .vec_q   (en_q)
   );

   icq_setclr_reg #(.W(NSRC)) u_mask (
      .clk     (clk),
      .rst     (rst),
      .set_stb (strobe.mk_set),
      .clr_stb (strobe.mk_clr),
      .bits    (wbits),
      .vec_q   (mask_q)
   );

   icq_pending #(.W(NSRC)) u_pend (
      .clk      (clk),
      .rst      (rst),
      .src_sync (src_s),
      .en_vec   (en_q),
      .ack_stb  (strobe.st_ack),
      .ack_bits (wbits),
      .stat_q   (stat_q)
   );

   assign live = stat_q & mask_q & en_q;

   always_ff @(posedge clk) begin
      if (rst) irq_out <= 1'b0;
      else     irq_out <= |live;
   end

endmodule

// File: rtl/irq_cascade_hub_chk.sv
module irq_cascade_hub_chk
   import icq_pkg::*;
#(
   parameter int unsigned NSRC   = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq_out,
   input logic [NSRC-1:0]   en_q,
   input logic [NSRC-1:0]   mask_q,
   input logic [NSRC-1:0]   stat_q
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] ck_idx;
   logic [NSRC-1:0]  ck_wd;
   logic [NSRC-1:0]  ck_ack;
   logic             ck_rst_q;

   assign ck_idx = bus_addr[ADDR_W-1:2];
   assign ck_wd  = bus_wdata[NSRC-1:0];
   assign ck_ack = (bus_wr && ck_idx == IDX_W'(IDX_STATUS)) ? ck_wd : '0;

   always_ff @(posedge clk) ck_rst_q <= rst;

   // R1: state cleared after a reset edge
   always @(negedge clk) begin
      if (ck_rst_q == 1'b1) begin
         a_r1_reset_clear: assert (en_q == '0 && mask_q == '0 && stat_q == '0 && !irq_out)
            else $error("a_r1_reset_clear");
      end
   end

   // R3
   a_r3_en_set: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && ck_idx == IDX_W'(IDX_EN_SET)) |=> ((en_q & $past(ck_wd)) == $past(ck_wd)));
   a_r3_en_clr: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && ck_idx == IDX_W'(IDX_EN_CLR)) |=> ((en_q & $past(ck_wd)) == '0));

   // R4
   a_r4_mask_set: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && ck_idx == IDX_W'(IDX_MSK_SET)) |=> ((mask_q & $past(ck_wd)) == $past(ck_wd)));
   a_r4_mask_clr: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && ck_idx == IDX_W'(IDX_MSK_CLR)) |=> ((mask_q & $past(ck_wd)) == '0));

   // R5: a status bit only rises where enable was set
   a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

   // R6: bits not acknowledged never drop
   a_r6_unacked_hold: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (($past(stat_q) & ~$past(ck_ack) & ~stat_q) == '0));

   // R7: request only rises when a live source existed
   a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_out) |-> $past(|(stat_q & mask_q & en_q)));

   // R8: nothing live means the request is low next cycle
   a_r8_gated_quiet: assert property (@(posedge clk) disable iff (rst)
      ((stat_q & mask_q & en_q) == '0) |=> !irq_out);

endmodule

bind irq_cascade_hub irq_cascade_hub_chk #(
   .NSRC   (NSRC),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .irq_out   (irq_out),
   .en_q      (en_q),
   .mask_q    (mask_q),
   .stat_q    (stat_q)
);

// File: tb/tb_irq_cascade_hub.sv
`timescale 1ns/1ps
module tb_irq_cascade_hub;

   localparam int unsigned NSRC = 16;
   localparam logic [4:0] A_STAT = 5'h00, A_ENS = 5'h04, A_ENC = 5'h08,
                          A_MKS = 5'h0C, A_MKC = 5'h10;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] src_irq;
   logic [4:0]  bus_addr;
   logic        bus_wr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic        irq_out;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_cascade_hub #(.NSRC(NSRC)) dut (
      .clk       (clk),
      .rst       (rst),
      .src_irq   (src_irq),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int    n_vec  = 0;
   int    n_bad  = 0;
   bit    done   = 1'b0;

   // monitor: compare 1 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {15'd0, irq_out} : bus_rdata;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
            end
         end
      end
   end

   task automatic exp_read(input logic [4:0] a, input logic [15:0] e, input string r);
      item_t it;
      bus_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.req = r;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic exp_irq(input logic e, input string r);
      item_t it;
      it.is_irq = 1'b1; it.exp = {15'd0, e}; it.req = r;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = 16'h0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; src_irq = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
      tick(4);
      rst = 1'b0;

      // R1 reset state
      exp_read(A_STAT, 16'h0000, "R1 status");
      exp_read(A_ENS,  16'h0000, "R1 enable");
      exp_read(A_MKS,  16'h0000, "R1 mask");
      exp_irq(1'b0, "R1 irq");

      // R2 / R3 enable set and aliases
      wr(A_ENS, 16'h00A5);
      exp_read(A_ENS, 16'h00A5, "R2 enable at 0x04");
      exp_read(A_ENC, 16'h00A5, "R2 enable at 0x08");
      exp_read(5'h14, 16'h0000, "R2 unused 0x14");
      exp_read(5'h1C, 16'h0000, "R2 unused 0x1C");
      wr(A_ENC, 16'h0005);
      exp_read(A_ENS, 16'h00A0, "R3 enable clear partial");
      wr(A_ENS, 16'h0100);
      exp_read(A_ENS, 16'h01A0, "R3 enable set keeps others");
      wr(A_ENC, 16'hFFFF);
      exp_read(A_ENC, 16'h0000, "R3 enable clear all");

      // R4 mask
      wr(A_MKS, 16'h3C00);
      exp_read(A_MKS, 16'h3C00, "R4 mask at 0x0C");
      exp_read(A_MKC, 16'h3C00, "R4 mask at 0x10");
      wr(A_MKC, 16'h0C00);
      exp_read(A_MKS, 16'h3000, "R4 mask clear partial");

      // R5 disabled source never sets, then enable
      src_irq = 16'h0001;
      tick(5);
      exp_read(A_STAT, 16'h0000, "R5 disabled source");
      wr(A_ENS, 16'h0001);
      exp_read(A_STAT, 16'h0001, "R5 set after enable");
      wr(A_ENS, 16'h0002);
      src_irq = 16'h0003;
      exp_read(A_STAT, 16'h0001, "R5 latency edge1");
      exp_read(A_STAT, 16'h0001, "R5 latency edge2");
      exp_read(A_STAT, 16'h0003, "R5 latency edge3");
      exp_irq(1'b0, "R8 mask gate off");

      // R7 registered output
      wr(A_MKS, 16'h0002);
      exp_irq(1'b1, "R7 irq after unmask");
      // R8 either gate
      wr(A_ENC, 16'h0002);
      exp_irq(1'b0, "R8 enable cleared");
      exp_read(A_STAT, 16'h0003, "R8 pending kept while gated");
      wr(A_ENS, 16'h0002);
      exp_irq(1'b1, "R7 irq re-enabled");
      wr(A_MKC, 16'h0002);
      exp_irq(1'b0, "R8 mask cleared");

      // R6 acknowledge
      wr(A_STAT, 16'h0001);
      exp_read(A_STAT, 16'h0003, "R6 set wins while active");
      src_irq = 16'h0000;
      tick(3);
      exp_read(A_STAT, 16'h0003, "R6 latched after source drop");
      wr(A_STAT, 16'h0001);
      exp_read(A_STAT, 16'h0002, "R6 zero bits unchanged");
      wr(A_STAT, 16'h0002);
      exp_read(A_STAT, 16'h0000, "R6 ack clears");

      // R10 multiple pending
      wr(A_ENS, 16'h8181);
      src_irq = 16'h8581;
      tick(4);
      exp_read(A_STAT, 16'h8181, "R10 several pending");
      exp_irq(1'b0, "R8 none unmasked");
      wr(A_MKS, 16'h8000);
      exp_irq(1'b1, "R7 irq bit15");

      // R9 init sequence
      wr(A_ENC, 16'hFFFF);
      wr(A_MKC, 16'hFFFF);
      wr(A_STAT, 16'hFFFF);
      exp_read(A_ENS,  16'h0000, "R9 enable zero");
      exp_read(A_MKS,  16'h0000, "R9 mask zero");
      exp_read(A_STAT, 16'h0000, "R9 status zero");
      exp_irq(1'b0, "R9 irq low");
      tick(4);
      exp_read(A_STAT, 16'h0000, "R9 stays clear with active sources");

      // R2 write to unused address has no effect
      wr(5'h14, 16'hFFFF);
      exp_read(A_ENS,  16'h0000, "R2 unused write enable");
      exp_read(A_MKS,  16'h0000, "R2 unused write mask");
      exp_read(A_STAT, 16'h0000, "R2 unused write status");

      tick(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule